// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block derives the clock sent to a memory card from the module clock. A programmable power-of-two divider sets the rate, and a gate opens and closes it on one-shot commands from a register-style control write. The gate only ever opens or closes while the divided clock is low, so the card never sees a shortened pulse. A status word reports when the gate is really open, so software can issue a stop and then poll until the clock has actually halted before it changes the rate.

A separate write port loads the divide exponent. A value written while the clock runs is held back and applied once the gate has closed. A soft-reset command closes the gate at once, clears the divider counter, and raises a busy flag for a fixed number of module clock cycles. The operation-start command bit may share a write with the start-clock bit and is forwarded as a one-cycle pulse to the command logic.

Top module: `card_clk_gate`

## Requirements
- R1: After `rst_n` is released, `card_clk` is 0, `op_go` is 0 and all bits of `status` are 0.
- R2: With divide exponent n, each high phase and each low phase of `card_clk` lasts 2^n module clock cycles, so exponent 7 gives a clock 128 times slower than exponent 0.
- R3: A control write with bit 2 set produces a single-cycle `op_go` pulse on the cycle after the write, but only if the gate is open after that write. A write of bit 2 alone while the gate is closed gives no pulse.
- R4: A stop command (control bit 0) closes the gate only while `card_clk` is low. A stop that arrives during a high phase lets that phase run to its full length before the gate closes. After the gate closes, `card_clk` stays at 0.
- R5: `status` bit 8 is 1 exactly while the gate is open. It becomes 1 in the cycle after an accepted start command (control bit 1), and it falls in the same cycle that `card_clk` is held low for the stop.
- R6: A divide exponent written while the gate is closed takes effect at once. One written while the gate is open leaves the running rate unchanged and applies after the next stop.
- R7: When control bits 0 and 1 are both set in one write, the stop wins. A closed gate stays closed, and an open gate closes.
- R8: A soft-reset command (control bit 3) closes the gate and clears the divider counter. `status` bit 15 is then 1 for exactly RST_CYCLES module clock cycles (8 by default), starting in the cycle after the write.
- R9: A start command written while `status` bit 15 is 1 is ignored, and the gate stays closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control bits: 0 stop, 1 start, 2 operation start, 3 soft reset |
| div_we | input | 1 | Divide-exponent write strobe |
| div_wdata | input | DIV_W | Divide exponent n (half period 2^n cycles) |
| card_clk | output | 1 | Gated, divided card clock |
| op_go | output | 1 | One-cycle operation-start pulse |
| status | output | 16 | Bit 8 gate open, bit 15 soft reset busy, others 0 |

## Verification
The bench builds the block with its default parameters: a 3-bit exponent and an 8-cycle soft reset. This puts the full divider range within reach, up to exponent 7 with its 128-cycle half periods, and lets the bench count the reset window exactly. The exponents tested are 0, 1, 3 and 7, which cover the single-cycle toggle, the counter wrap and the widest count. Stops are placed both inside a high phase and inside a low phase, so that both ways the gate can close are exercised.

// File: rtl/card_clk_gate.sv
module card_clk_gate #(
  parameter int DIV_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic             card_clk,
  output logic             op_go,
  output logic [15:0]      status
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);

  logic             run, ck, stop_pend, pend_v;
  logic [CNT_W-1:0] cnt, mask;
  logic [CNT_W:0]   span;
  logic [DIV_W-1:0] div_cur, div_pend;
  logic [RC_W-1:0]  rst_cnt;
  logic             busy, stop_cmd, start_cmd, srst_cmd;
  logic             half_tick, closing, opening, run_nxt;

  assign busy      = rst_cnt != '0;
  assign stop_cmd  = ctl_we & ctl_wdata[0];
  assign start_cmd = ctl_we & ctl_wdata[1] & ~ctl_wdata[0];
  assign srst_cmd  = ctl_we & ctl_wdata[3];

  assign span      = (CNT_W+1)'(1) << div_cur;
  assign mask      = CNT_W'(span - 1'b1);
  assign half_tick = cnt == mask;

  assign closing = run & (stop_pend | stop_cmd) & (~ck | half_tick);
  assign opening = ~run & start_cmd & ~busy & ~srst_cmd;

  always_comb begin
    if (busy || srst_cmd) run_nxt = 1'b0;
    else if (opening)     run_nxt = 1'b1;
    else if (closing)     run_nxt = 1'b0;
    else                  run_nxt = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      ck        <= 1'b0;
      cnt       <= '0;
      stop_pend <= 1'b0;
      rst_cnt   <= '0;
      op_go     <= 1'b0;
    end else begin
      op_go <= ctl_we & ctl_wdata[2] & run_nxt;
      if (srst_cmd)  rst_cnt <= RC_W'(RST_CYCLES);
      else if (busy) rst_cnt <= rst_cnt - 1'b1;
      if (srst_cmd || busy || opening || closing) begin
        run       <= run_nxt;
        ck        <= 1'b0;
        cnt       <= '0;
        stop_pend <= 1'b0;
      end else if (run) begin
        cnt <= half_tick ? '0 : cnt + 1'b1;
        if (half_tick) ck <= ~ck;
        if (stop_cmd) stop_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cur  <= '0;
      div_pend <= '0;
      pend_v   <= 1'b0;
    end else if (div_we && !run) begin
      div_cur <= div_wdata;
      pend_v  <= 1'b0;
    end else if (div_we) begin
      div_pend <= div_wdata;
      pend_v   <= 1'b1;
    end else if (!run && pend_v) begin
      div_cur <= div_pend;
      pend_v  <= 1'b0;
    end
  end

  assign card_clk = ck;
  assign status   = {busy, 6'b0, run, 8'b0};

  // R4
  gate_open_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !ck);
  // R4
  closed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !ck);
  // R2
  rise_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck) |-> $past(run));
  // R6
  div_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div_cur));
  // R8
  reset_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !run);
  // R7
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[0] && ctl_wdata[1] && !run) |=> !run);
endmodule

// File: tb/card_clk_gate_tb.sv
module card_clk_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'b0;
  logic       div_we = 1'b0;
  logic [2:0] div_wdata = 3'b0;
  logic       card_clk, op_go;
  logic [15:0] status;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] EXPS  [4] = '{3'd0, 3'd1, 3'd3, 3'd7};
  localparam int         HALFS [4] = '{1, 2, 8, 128};

  always #2 clk = ~clk;

  card_clk_gate u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .card_clk(card_clk),
    .op_go(op_go), .status(status)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [3:0] d);
    ctl_we = 1'b1; ctl_wdata = d; tick(); ctl_we = 1'b0; ctl_wdata = 4'b0;
  endtask

  task automatic wr_div(input logic [2:0] d);
    div_we = 1'b1; div_wdata = d; tick(); div_we = 1'b0;
  endtask

  task automatic wait_rise();
    for (int k = 0; k < 400 && !card_clk; k++) tick();
  endtask

  task automatic count_high(output int h);
    h = 0;
    while (card_clk && h < 400) begin h++; tick(); end
  endtask

  task automatic count_low(output int l);
    l = 0;
    while (!card_clk && l < 400) begin l++; tick(); end
  endtask

  task automatic stop_and_poll(input string tag);
    int w;
    wr_ctl(4'b0001);
    w = 0;
    while (status[8] && w < 400) begin w++; tick(); end
    check(status[8] == 1'b0, tag, status[8], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, l, b, q;
    repeat (3) tick();
    check(card_clk == 0 && op_go == 0 && status == 16'h0, "R1 reset state", status, 0);
    rst_n = 1'b1;
    tick();
    check(card_clk == 0 && status == 16'h0, "R1 after release", status, 0);

    for (int i = 0; i < 4; i++) begin
      wr_div(EXPS[i]);
      wr_ctl(4'b0010);
      check(status[8] == 1'b1, "R5 open after start", status[8], 1);
      wait_rise();
      count_high(h);
      count_low(l);
      check(h == HALFS[i], "R2 high phase", h, HALFS[i]);
      check(l == HALFS[i], "R2 low phase", l, HALFS[i]);
      stop_and_poll("R5 closes after stop");
      q = 0;
      for (int k = 0; k < 20; k++) begin if (card_clk) q++; tick(); end
      check(q == 0, "R4 quiet when closed", q, 0);
    end

    wr_ctl(4'b0110);
    check(op_go == 1'b1, "R3 pulse with start", op_go, 1);
    tick();
    check(op_go == 1'b0, "R3 pulse one cycle", op_go, 0);
    stop_and_poll("R3 stop");
    wr_ctl(4'b0100);
    check(op_go == 1'b0, "R3 no pulse when closed", op_go, 0);

    wr_div(3'd1);
    wr_ctl(4'b0010);
    wr_div(3'd2);
    wait_rise();
    count_high(h);
    check(h == 2, "R6 held while running", h, 2);
    stop_and_poll("R6 stop");
    tick();
    wr_ctl(4'b0010);
    wait_rise();
    count_high(h);
    check(h == 4, "R6 applied after stop", h, 4);
    stop_and_poll("R6 stop again");

    wr_ctl(4'b0011);
    check(status[8] == 1'b0, "R7 closed stays closed", status[8], 0);
    q = 0;
    for (int k = 0; k < 10; k++) begin if (card_clk) q++; tick(); end
    check(q == 0, "R7 no clock", q, 0);
    wr_ctl(4'b0010);
    tick();
    wr_ctl(4'b0011);
    b = 0;
    while (status[8] && b < 400) begin b++; tick(); end
    check(status[8] == 1'b0, "R7 open gate closes", status[8], 0);

    wr_div(3'd3);
    wr_ctl(4'b0010);
    wait_rise();
    h = 1;
    wr_ctl(4'b0001);
    while (card_clk && h < 400) begin
      h++;
      check(status[8] == 1'b1, "R5 open through high phase", status[8], 1);
      tick();
    end
    check(h == 8, "R4 high phase completes", h, 8);
    check(status[8] == 1'b0, "R5 falls with clock", status[8], 0);

    wr_ctl(4'b0010);
    wait_rise();
    count_high(h);
    wr_ctl(4'b0001);
    check(status[8] == 1'b0 && card_clk == 1'b0, "R4 stop during low", status[8], 0);

    wr_ctl(4'b0010);
    repeat (5) tick();
    wr_ctl(4'b1000);
    check(status[15] == 1'b1 && status[8] == 1'b0 && card_clk == 1'b0,
          "R8 reset closes gate", status, 16'h8000);
    b = 0;
    while (status[15] && b < 50) begin
      b++;
      ctl_we = (b == 3); ctl_wdata = 4'b0010;
      tick();
    end
    ctl_we = 1'b0; ctl_wdata = 4'b0;
    check(b == 8, "R8 busy length", b, 8);
    check(status[8] == 1'b0, "R9 start ignored in reset", status[8], 0);
    wr_ctl(4'b0010);
    check(status[8] == 1'b1, "R8 start after reset", status[8], 1);
    stop_and_poll("R8 final stop");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule